// File: doc/BRIEF.md
# T1 Receive Alarm Pin Generator

This block sits behind a T1 receive framer and turns the framer's internal event strobes into real-time alarm pins, each with its own timing rule. Loss of sync, yellow alarm, bipolar violation and frame error each get their own pin. The frame error pin also carries CRC6 code word errors in the extended superframe format. The block also makes a multiframe sync pin and a status word. In that word the loss-of-sync and yellow alarm conditions are held until the host has read them.

Everything runs on the receive bit clock. A bit-time enable marks valid bit slots, an F-bit marker flags the framing bit and a multiframe marker flags the first bit of each multiframe. Framing search, line decoding, yellow detection and CRC computation are all upstream; their results arrive here as strobes. After reset is released the block sends the framer a one-clock request to resynchronize at once.

Top module: `t1_rx_alarm_out`

## Requirements
- R1: With `manual_resync_i` = 1, `los_o` equals the `resync_busy_i` value sampled at the previous rising clock edge.
- R2: With `manual_resync_i` = 0 (automatic resync), `los_o` equals the `los_oof_i` value sampled at the previous rising clock edge.
- R3: `yel_o` equals the `yel_det_i` value sampled at the previous rising clock edge.
- R4: On a rising edge with `bit_en_i` = 1, `bv_o` takes the value of `bpv_i`. A violation therefore gives a high of one bit time, and consecutive violations keep it high. Between enabled bits `bv_o` holds its value.
- R5: At an enabled F-bit (`bit_en_i` = 1 and `fbit_mark_i` = 1), a frame bit error raises `fer_o` from the next rising edge for 2 enabled bit times. The error is `ftfs_err_i` when `ext_frame_i` = 0 and `fps_err_i` when `ext_frame_i` = 1. An error strobe outside the F-bit, or the strobe of the format that is not selected, is ignored.
- R6: With `ext_frame_i` = 1, a `crc6_err_i` strobe in an enabled bit that also carries `mfsync_mark_i` gives a pulse on `fer_o` one clock period wide. The pulse rises on the falling clock edge half a period before `mfsync_o` rises. With `ext_frame_i` = 0 the strobe is ignored.
- R7: When a CRC6 pulse and a frame error stretch overlap, `fer_o` is their OR.
- R8: Status bit 3 is the held copy of `los_o` and bit 4 the held copy of `yel_o`; all other status bits read 0. A held bit is 1 in the clock after its pin is 1. It stays 1 until a cycle in which `stat_rd_i` = 1 while the pin is 0, and it reads 0 from the next clock on.
- R9: While `rst_n_i` is low, every output is 0. The first rising edge after release raises `resync_req_o` for exactly one clock.
- R10: On a rising edge with `bit_en_i` = 1, `mfsync_o` takes the value of `mfsync_mark_i`; otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Marks a valid bit slot |
| fbit_mark_i | input | 1 | Current bit is the framing bit |
| mfsync_mark_i | input | 1 | Current bit starts a multiframe |
| resync_busy_i | input | 1 | Off-line resynchronization in progress |
| los_oof_i | input | 1 | Carrier loss or out-of-frame, real time |
| yel_det_i | input | 1 | Yellow alarm detected |
| bpv_i | input | 1 | Bipolar violation on the current serial bit |
| ftfs_err_i | input | 1 | Terminal/signalling framing pattern error (superframe) |
| fps_err_i | input | 1 | Framing pattern sequence error (extended superframe) |
| crc6_err_i | input | 1 | CRC6 mismatch for the multiframe just ended |
| ext_frame_i | input | 1 | 1 = extended superframe, 0 = superframe |
| manual_resync_i | input | 1 | 1 = show resync progress, 0 = show carrier/OOF |
| stat_rd_i | input | 1 | Host reads the status word this cycle |
| los_o | output | 1 | Loss of sync pin |
| yel_o | output | 1 | Yellow alarm pin |
| bv_o | output | 1 | Bipolar violation pin |
| fer_o | output | 1 | Frame error / CRC6 error pin |
| mfsync_o | output | 1 | Multiframe sync pin |
| resync_req_o | output | 1 | One-clock resync request to the framer |
| stat_o | output | STAT_W | Status word with held alarm bits |

## Verification
Two conditions can meet on the frame error pin in the same clock: the 2-bit frame error stretch and the CRC6 pulse. The bench provokes this with a directed sequence. An F-bit with a pattern error in extended format is followed in the next bit by a multiframe marker carrying a CRC6 error, and random traffic also produces the case. A reference model advances both sources separately and checks every clock that the pin shows their OR and that the CRC pulse is already high while the multiframe sync pin is still low.

// File: rtl/t1alm_pkg.sv
package t1alm_pkg;
   // Framing format selected by ext_frame_i
   typedef enum logic {
      FMT_SUPER = 1'b0,
      FMT_EXTND = 1'b1
   } frame_fmt_e;

   // Pick the framing error strobe that belongs to the active format
   function automatic logic pick_frame_err(input frame_fmt_e fmt,
                                           input logic ftfs_err,
                                           input logic fps_err);
      return (fmt == FMT_EXTND) ? fps_err : ftfs_err;
   endfunction
endpackage

// File: rtl/t1alm_fer_stretch.sv
module t1alm_fer_stretch #(
   parameter int LEN = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic bit_en_i,
   input  logic start_i,
   output logic active_o
);
   localparam int CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LOAD = CW'(LEN);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q <= '0;
      end else if (bit_en_i) begin
         if (start_i) begin
            cnt_q <= LOAD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign active_o = (cnt_q != '0);
endmodule

// File: rtl/t1alm_crc_mark.sv
module t1alm_crc_mark #(
   parameter bit HALF_EARLY = 1'b1
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic arm_i,
   output logic pulse_o
);
   logic pulse_q;

   generate
      if (HALF_EARLY) begin : g_fall
         // Launched on the falling edge: leads the sync rise by half a clock
         always_ff @(negedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) pulse_q <= 1'b0;
            else          pulse_q <= arm_i;
         end
      end else begin : g_rise
         // Launched with the sync rise on the same rising edge
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) pulse_q <= 1'b0;
            else          pulse_q <= arm_i;
         end
      end
   endgenerate

   assign pulse_o = pulse_q;
endmodule

// File: rtl/t1alm_sticky.sv
module t1alm_sticky (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic alarm_i,
   input  logic rd_i,
   output logic held_o
);
   logic held_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) held_q <= 1'b0;
      else          held_q <= alarm_i | (held_q & ~rd_i);
   end

   assign held_o = held_q;
endmodule

// File: rtl/t1_rx_alarm_out.sv
module t1_rx_alarm_out
   import t1alm_pkg::*;
#(
   parameter int STAT_W     = 8,
   parameter int LOS_BIT    = 3,
   parameter int YEL_BIT    = 4,
   parameter int FER_BITS   = 2,
   parameter bit CRC_HALF_EARLY = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              bit_en_i,
   input  logic              fbit_mark_i,
   input  logic              mfsync_mark_i,
   input  logic              resync_busy_i,
   input  logic              los_oof_i,
   input  logic              yel_det_i,
   input  logic              bpv_i,
   input  logic              ftfs_err_i,
   input  logic              fps_err_i,
   input  logic              crc6_err_i,
   input  logic              ext_frame_i,
   input  logic              manual_resync_i,
   input  logic              stat_rd_i,
   output logic              los_o,
   output logic              yel_o,
   output logic              bv_o,
   output logic              fer_o,
   output logic              mfsync_o,
   output logic              resync_req_o,
   output logic [STAT_W-1:0] stat_o
);
   localparam int N_HELD = 2;
   localparam int HELD_POS [N_HELD] = '{LOS_BIT, YEL_BIT};

   initial begin
      if (STAT_W < 1 || LOS_BIT >= STAT_W || YEL_BIT >= STAT_W || LOS_BIT < 0 || YEL_BIT < 0)
         $fatal(1, "status bit position outside status word");
      if (LOS_BIT == YEL_BIT)
         $fatal(1, "status bit positions must differ");
      if (FER_BITS < 1)
         $fatal(1, "frame error stretch must be at least one bit");
   end

   frame_fmt_e fmt;
   assign fmt = frame_fmt_e'(ext_frame_i);

   // Real-time level pins
   logic los_q, yel_q, bv_q, mf_q;
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         los_q <= 1'b0;
         yel_q <= 1'b0;
         bv_q  <= 1'b0;
         mf_q  <= 1'b0;
      end else begin
         los_q <= manual_resync_i ? resync_busy_i : los_oof_i;
         yel_q <= yel_det_i;
         if (bit_en_i) begin
            bv_q <= bpv_i;
            mf_q <= mfsync_mark_i;
         end
      end
   end

   // Frame bit error stretch
   logic fer_start, fer_stretch;
   assign fer_start = fbit_mark_i & pick_frame_err(fmt, ftfs_err_i, fps_err_i);

   t1alm_fer_stretch #(.LEN(FER_BITS)) u_stretch (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .bit_en_i (bit_en_i),
      .start_i  (fer_start),
      .active_o (fer_stretch)
   );

   // CRC6 error marker ahead of the multiframe sync rise
   logic crc_arm, crc_pulse;
   assign crc_arm = bit_en_i & mfsync_mark_i & crc6_err_i & (fmt == FMT_EXTND);

   t1alm_crc_mark #(.HALF_EARLY(CRC_HALF_EARLY)) u_crc (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .arm_i   (crc_arm),
      .pulse_o (crc_pulse)
   );

   // Post-reset resync request
   logic req_q, req_done_q;
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         req_q      <= 1'b0;
         req_done_q <= 1'b0;
      end else begin
         req_q      <= ~req_done_q;
         req_done_q <= 1'b1;
      end
   end

   // Held status bits
   logic [N_HELD-1:0] held_src, held_val;
   assign held_src = {yel_q, los_q};

   always_comb begin
      stat_o = '0;
      for (int k = 0; k < N_HELD; k++) stat_o[HELD_POS[k]] = held_val[k];
   end

   generate
      for (genvar g = 0; g < N_HELD; g++) begin : g_held
         t1alm_sticky u_sticky (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .alarm_i (held_src[g]),
            .rd_i    (stat_rd_i),
            .held_o  (held_val[g])
         );
      end
   endgenerate

   assign los_o        = los_q;
   assign yel_o        = yel_q;
   assign bv_o         = bv_q;
   assign mfsync_o     = mf_q;
   assign fer_o        = fer_stretch | crc_pulse;
   assign resync_req_o = req_q;
endmodule

// File: rtl/t1alm_chk.sv
module t1alm_chk #(
   parameter int STAT_W  = 8,
   parameter int LOS_BIT = 3,
   parameter int YEL_BIT = 4
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic              bit_en_i,
   input logic              fbit_mark_i,
   input logic              resync_busy_i,
   input logic              yel_det_i,
   input logic              bpv_i,
   input logic              ftfs_err_i,
   input logic              fps_err_i,
   input logic              ext_frame_i,
   input logic              manual_resync_i,
   input logic              los_o,
   input logic              yel_o,
   input logic              bv_o,
   input logic              fer_o,
   input logic              resync_req_o,
   input logic [STAT_W-1:0] stat_o
);
   assert_manual_los_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (manual_resync_i && resync_busy_i) |=> los_o);

   assert_yel_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      yel_det_i |=> yel_o);

   assert_bv_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (bit_en_i && bpv_i) |=> bv_o);

   assert_bv_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !bit_en_i |=> $stable(bv_o));

   assert_fer_start_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (bit_en_i && fbit_mark_i && (ext_frame_i ? fps_err_i : ftfs_err_i)) |=> fer_o);

   assert_held_los_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      los_o |=> stat_o[LOS_BIT]);

   assert_held_yel_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      yel_o |=> stat_o[YEL_BIT]);

   assert_req_single_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      resync_req_o |=> !resync_req_o);
endmodule

bind t1_rx_alarm_out t1alm_chk #(
   .STAT_W (STAT_W),
   .LOS_BIT(LOS_BIT),
   .YEL_BIT(YEL_BIT)
) u_chk (
   .clk_i           (clk_i),
   .rst_n_i         (rst_n_i),
   .bit_en_i        (bit_en_i),
   .fbit_mark_i     (fbit_mark_i),
   .resync_busy_i   (resync_busy_i),
   .yel_det_i       (yel_det_i),
   .bpv_i           (bpv_i),
   .ftfs_err_i      (ftfs_err_i),
   .fps_err_i       (fps_err_i),
   .ext_frame_i     (ext_frame_i),
   .manual_resync_i (manual_resync_i),
   .los_o           (los_o),
   .yel_o           (yel_o),
   .bv_o            (bv_o),
   .fer_o           (fer_o),
   .resync_req_o    (resync_req_o),
   .stat_o          (stat_o)
);

// File: tb/t1_rx_alarm_out_tb_top.sv
`timescale 1ns/1ps
module t1_rx_alarm_out_tb_top;
   localparam int STAT_W = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, be, fb, mf, busy, oof, yel, bpv, ftfs, fps, crc, ext, man, rd;
   logic los_o, yel_o, bv_o, fer_o, mfsync_o, req_o;
   logic [STAT_W-1:0] stat_o;

   t1_rx_alarm_out dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .bit_en_i(be), .fbit_mark_i(fb),
      .mfsync_mark_i(mf), .resync_busy_i(busy), .los_oof_i(oof),
      .yel_det_i(yel), .bpv_i(bpv), .ftfs_err_i(ftfs), .fps_err_i(fps),
      .crc6_err_i(crc), .ext_frame_i(ext), .manual_resync_i(man),
      .stat_rd_i(rd), .los_o(los_o), .yel_o(yel_o), .bv_o(bv_o),
      .fer_o(fer_o), .mfsync_o(mfsync_o), .resync_req_o(req_o), .stat_o(stat_o)
   );

   // next stimulus, set by the scenario before each cycle
   logic n_rst, n_be, n_fb, n_mf, n_busy, n_oof, n_yel, n_bpv, n_ftfs, n_fps, n_crc, n_ext, n_man, n_rd;

   // reference model state
   logic m_los, m_yel, m_bv, m_mf, m_req, m_done, m_crc, m_hlos, m_hyel;
   int   m_cnt;
   int   vectors = 0, fails = 0;
   bit   finished = 0;

   task automatic model_edge();
      logic o_los, o_yel;
      if (!rst_n) return;
      o_los = m_los; o_yel = m_yel;
      m_los = man ? busy : oof;
      m_yel = yel;
      if (be) begin
         m_bv = bpv;
         m_mf = mf;
         if (fb && (ext ? fps : ftfs)) m_cnt = 2;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
      m_hlos = o_los | (m_hlos & !rd);
      m_hyel = o_yel | (m_hyel & !rd);
      m_req  = !m_done;
      m_done = 1'b1;
   endtask

   task automatic model_clear();
      m_los = 0; m_yel = 0; m_bv = 0; m_mf = 0; m_req = 0; m_done = 0;
      m_crc = 0; m_hlos = 0; m_hyel = 0; m_cnt = 0;
   endtask

   task automatic chk1(input logic act, input logic exp, input string what);
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %b expected %b", what, $time, act, exp);
      end
   endtask

   task automatic cyc();
      logic [STAT_W-1:0] exp_stat;
      @(posedge clk);
      model_edge();
      #1;
      rst_n = n_rst; be = n_be; fb = n_fb; mf = n_mf; busy = n_busy; oof = n_oof;
      yel = n_yel; bpv = n_bpv; ftfs = n_ftfs; fps = n_fps; crc = n_crc;
      ext = n_ext; man = n_man; rd = n_rd;
      if (!rst_n) model_clear();
      // falling edge at +2.5 captures the CRC marker from these inputs
      m_crc = rst_n & be & mf & crc & ext;
      #3;
      vectors++;
      exp_stat = '0;
      exp_stat[3] = m_hlos;
      exp_stat[4] = m_hyel;
      chk1(los_o, m_los, man ? "R1 los_o (manual)" : "R2 los_o (auto)");
      chk1(yel_o, m_yel, "R3 yel_o");
      chk1(bv_o, m_bv, "R4 bv_o");
      chk1(fer_o, (m_cnt != 0) | m_crc, "R5/R6/R7 fer_o");
      chk1(mfsync_o, m_mf, "R10 mfsync_o");
      chk1(req_o, m_req, "R9 resync_req_o");
      if (stat_o !== exp_stat) begin
         fails++;
         $display("FAIL R8 stat_o at %0t: actual %h expected %h", $time, stat_o, exp_stat);
      end
   endtask

   task automatic idle();
      n_be = 1; n_fb = 0; n_mf = 0; n_busy = 0; n_oof = 0; n_yel = 0; n_bpv = 0;
      n_ftfs = 0; n_fps = 0; n_crc = 0; n_rd = 0;
   endtask

   initial begin
      rst_n = 0; be = 0; fb = 0; mf = 0; busy = 0; oof = 0; yel = 0; bpv = 0;
      ftfs = 0; fps = 0; crc = 0; ext = 0; man = 0; rd = 0;
      model_clear();
      idle(); n_rst = 0; n_ext = 1; n_man = 1;
      // R9: outputs held at zero while reset is low, even with strobes active
      n_yel = 1; n_bpv = 1; n_busy = 1;
      repeat (3) cyc();
      idle(); n_rst = 1;
      repeat (4) cyc();                 // R9 single request after release

      // R1 manual mode follows resync progress, R8 held bit and read clear
      n_busy = 1; repeat (3) cyc();
      n_busy = 0; repeat (2) cyc();
      n_rd = 1; cyc(); n_rd = 0; repeat (2) cyc();
      // R2 auto mode follows carrier/OOF, busy ignored
      n_man = 0; n_busy = 1; n_oof = 1; repeat (2) cyc();
      n_oof = 0; n_busy = 0; n_rd = 1; repeat (3) cyc(); n_rd = 0;
      // R3 yellow and read while still active keeps held bit
      n_yel = 1; n_rd = 1; repeat (3) cyc(); n_yel = 0; repeat (2) cyc(); n_rd = 0;
      // R4 single, consecutive, and held across disabled bits
      n_bpv = 1; cyc(); n_bpv = 0; cyc();
      n_bpv = 1; repeat (3) cyc(); n_be = 0; n_bpv = 0; repeat (2) cyc(); n_be = 1; repeat (2) cyc();
      // R5 extended: fps error at F-bit; ftfs ignored; error off F-bit ignored
      n_fb = 1; n_fps = 1; cyc(); n_fb = 0; n_fps = 0; repeat (3) cyc();
      n_fb = 1; n_ftfs = 1; cyc(); n_fb = 0; n_ftfs = 0; repeat (2) cyc();
      n_fps = 1; cyc(); n_fps = 0; repeat (2) cyc();
      // R5 superframe: ftfs counted
      n_ext = 0; n_fb = 1; n_ftfs = 1; cyc(); n_fb = 0; n_ftfs = 0; repeat (3) cyc();
      // R6 ignored in superframe
      n_mf = 1; n_crc = 1; cyc(); n_mf = 0; n_crc = 0; repeat (2) cyc();
      // R6 extended: pulse ahead of mfsync rise; R10 marker follows
      n_ext = 1; n_mf = 1; n_crc = 1; cyc(); n_mf = 0; n_crc = 0; repeat (2) cyc();
      // R7 overlap: F-bit error then CRC marker next bit
      n_fb = 1; n_fps = 1; cyc(); n_fb = 0; n_fps = 0; n_mf = 1; n_crc = 1; cyc();
      n_mf = 0; n_crc = 0; repeat (3) cyc();
      // R10 marker with enable low is not taken
      n_be = 0; n_mf = 1; cyc(); n_mf = 0; n_be = 1; repeat (2) cyc();

      // random traffic with a mid-run reset
      for (int i = 0; i < 4000; i++) begin
         n_rst  = !(i >= 2000 && i < 2003);
         n_be   = ($urandom_range(0, 9) < 8);
         n_fb   = ($urandom_range(0, 7) == 0);
         n_mf   = ($urandom_range(0, 5) == 0);
         n_busy = ($urandom_range(0, 3) == 0);
         n_oof  = ($urandom_range(0, 3) == 0);
         n_yel  = ($urandom_range(0, 3) == 0);
         n_bpv  = ($urandom_range(0, 2) == 0);
         n_ftfs = $urandom_range(0, 1);
         n_fps  = $urandom_range(0, 1);
         n_crc  = $urandom_range(0, 1);
         n_rd   = ($urandom_range(0, 3) == 0);
         if (i % 200 == 0) begin
            n_ext = $urandom_range(0, 1);
            n_man = $urandom_range(0, 1);
         end
         cyc();
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired: actual running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule